// File: doc/BRIEF.md
# Double-Buffered Time-Aware Gate Scheduler

This block opens and closes the transmit gates of eight egress queues on a repeating time schedule. The schedule is a gate control list of up to sixteen windows. Each window has a queue mask and an end time measured from the start of the cycle. A nanosecond cycle timer runs while the scheduler is enabled. It advances by a fixed step on every clock and wraps at the cycle time. The window whose end time has not yet been reached drives the gate-open vector.

Two list banks are held. One is active and the other is the shadow. Software writes window entries into the shadow bank, then issues a trigger that carries the new cycle time, the number of used windows and a change count. An accepted trigger raises a change flag and a pending flag. The scheduler drops the change flag on the next clock as an acknowledgement. After the requested number of cycle boundaries it swaps the banks and clears pending. Separate commands enable, disable or fully clear the scheduler. A per-queue maximum frame size table is kept alongside the lists.

Top module: `gate_sched`

## Requirements
- R1: After asynchronous reset, `gate_o` is all ones, `act_idx_o`, `change_o`, `pending_o` and `err_o` are 0, and every 16-bit field of `max_sdu_o` holds 2048.
- R2: While enabled with a non-empty active list, bit i of `gate_o` opens queue i and equals bit i of the mask of window w, for the cycle time t in [end(w-1), end(w)). Here end(-1)=0, and t starts at 0 on the edge that accepts the enable command and grows by STEP_NS per clock.
- R3: The last used window always ends at the cycle time, whatever end time was written for it. Entries at or beyond the list length never drive `gate_o`. At t = cycle time the timer returns to 0 and to window 0.
- R4: A trigger is rejected when its cycle time lies outside [MIN_CYC_NS, MAX_CYC_NS], when its length is 0 or above 16, or when a swap is still pending. A rejected trigger raises `err_o` for one clock and changes neither the running schedule nor the flags.
- R5: An accepted trigger sets `change_o` and `pending_o` on its edge, and `change_o` returns to 0 on the next edge.
- R6: `pending_o` falls and `act_idx_o` toggles on the edge of the N-th cycle wrap after the trigger, where N is the change count and a count of 0 acts as 1. The new list starts at t = 0 on that same edge.
- R7: If the active list is empty (length 0), a pending swap happens on the next edge, whether or not the scheduler is enabled.
- R8: Command value 0 disables the scheduler: `gate_o` is all ones, the timer halts and the lists are kept. Value 1 enables it and restarts at t = 0. Value 2 clears both lists, sets `act_idx_o` to 0, restores every max frame size to 2048, clears the flags and disables. Value 3 is rejected and raises `err_o` for one clock.
- R9: A max frame size write places `sdu_val_i` in the field of queue `sdu_q_i`, which is bits [16q+15:16q] of `max_sdu_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command strobe |
| cmd_i | input | 2 | Command: 0 disable, 1 enable, 2 clear, 3 invalid |
| sh_we_i | input | 1 | Shadow entry write strobe |
| sh_idx_i | input | 4 | Shadow entry index |
| sh_mask_i | input | 8 | Gate mask for the entry |
| sh_end_i | input | 32 | Cumulative end time for the entry, in ns |
| adm_cycle_i | input | 32 | Cycle time carried by a trigger, in ns |
| adm_len_i | input | 5 | Number of used entries carried by a trigger |
| chg_count_i | input | 8 | Cycle boundaries before the swap |
| trig_i | input | 1 | Trigger strobe |
| sdu_we_i | input | 1 | Max frame size write strobe |
| sdu_q_i | input | 3 | Queue for the max frame size write |
| sdu_val_i | input | 16 | Max frame size value |
| gate_o | output | 8 | Gate-open vector, one bit per queue |
| act_idx_o | output | 1 | Index of the active bank |
| change_o | output | 1 | Trigger received, not yet acknowledged |
| pending_o | output | 1 | Swap pending |
| err_o | output | 1 | One-clock error pulse |
| max_sdu_o | output | 128 | Per-queue max frame sizes, 16 bits each |

## Verification
The assertions assume that window end times written for used entries strictly increase and stay below the cycle time. They also assume that the cycle time is a multiple of the timer step and that no enable command lands on the same edge as a cycle wrap. The shadow bank is never written while a swap is pending. The bench builds its schedules with rising end times that end below the cycle time, uses a step of one nanosecond, and issues commands only at points where the timer is not at its last count. It writes shadow entries only before a trigger.

// File: rtl/gs_pkg.sv
package gs_pkg;
  typedef enum logic [1:0] {
    CMD_OFF = 2'd0,
    CMD_ON  = 2'd1,
    CMD_CLR = 2'd2,
    CMD_BAD = 2'd3
  } gs_cmd_e;
endpackage

// File: rtl/gs_gcl_store.sv
module gs_gcl_store #(
  parameter int NQ = 8,
  parameter int NW = 16,
  parameter int TW = 32,
  localparam int IW = $clog2(NW),
  localparam int LW = $clog2(NW + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          act_i,
  input  logic          we_i,
  input  logic [IW-1:0] widx_i,
  input  logic [NQ-1:0] wmask_i,
  input  logic [TW-1:0] wend_i,
  input  logic          commit_i,
  input  logic [TW-1:0] ccyc_i,
  input  logic [LW-1:0] clen_i,
  input  logic [IW-1:0] rptr_i,
  output logic [NQ-1:0] mask_o,
  output logic [TW-1:0] end_o,
  output logic [TW-1:0] cyc_o,
  output logic [LW-1:0] len_o
);
  logic [NQ-1:0] mask_q [2][NW];
  logic [TW-1:0] end_q  [2][NW];
  logic [TW-1:0] cyc_q  [2];
  logic [LW-1:0] len_q  [2];
  logic          sh;

  assign sh = ~act_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int b = 0; b < 2; b++) begin
        cyc_q[b] <= '0;
        len_q[b] <= '0;
        for (int i = 0; i < NW; i++) begin
          mask_q[b][i] <= '0;
          end_q[b][i]  <= '0;
        end
      end
    end else if (clr_i) begin
      for (int b = 0; b < 2; b++) begin
        cyc_q[b] <= '0;
        len_q[b] <= '0;
        for (int i = 0; i < NW; i++) begin
          mask_q[b][i] <= '0;
          end_q[b][i]  <= '0;
        end
      end
    end else begin
      if (we_i) begin
        mask_q[sh][widx_i] <= wmask_i;
        end_q[sh][widx_i]  <= wend_i;
      end
      if (commit_i) begin
        cyc_q[sh] <= ccyc_i;
        len_q[sh] <= clen_i;
        for (int i = 0; i < NW; i++) begin
          if (i >= int'(clen_i)) begin
            mask_q[sh][i] <= '0;
            end_q[sh][i]  <= '0;
          end else if (i == int'(clen_i) - 1) begin
            end_q[sh][i] <= ccyc_i;  // last window fills the cycle
          end
        end
      end
    end
  end

  assign mask_o = mask_q[act_i][rptr_i];
  assign end_o  = end_q[act_i][rptr_i];
  assign cyc_o  = cyc_q[act_i];
  assign len_o  = len_q[act_i];

  AST_LEN_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(len_o) <= NW);  // R4
endmodule

// File: rtl/gs_cycle_timer.sv
module gs_cycle_timer #(
  parameter int NW      = 16,
  parameter int TW      = 32,
  parameter int STEP_NS = 8,
  localparam int IW = $clog2(NW)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic          restart_i,
  input  logic [TW-1:0] cyc_i,
  input  logic [TW-1:0] end_i,
  input  logic          last_i,
  output logic [IW-1:0] ptr_o,
  output logic          wrap_o
);
  localparam logic [TW:0] STEP = (TW+1)'(STEP_NS);

  logic [TW-1:0] t_q;
  logic [TW:0]   t_nx;

  assign t_nx   = {1'b0, t_q} + STEP;
  assign wrap_o = run_i && (t_nx >= {1'b0, cyc_i});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      t_q   <= '0;
      ptr_o <= '0;
    end else if (restart_i) begin
      t_q   <= '0;
      ptr_o <= '0;
    end else if (run_i) begin
      if (wrap_o) begin
        t_q   <= '0;
        ptr_o <= '0;
      end else begin
        t_q <= t_nx[TW-1:0];
        if (t_nx >= {1'b0, end_i} && !last_i) ptr_o <= ptr_o + IW'(1);
      end
    end
  end

  AST_T_IN_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> t_q < cyc_i);  // R3
  AST_PTR_RESET_ON_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wrap_o && !restart_i) |=> ptr_o == '0);  // R3
endmodule

// File: rtl/gate_sched.sv
module gate_sched
  import gs_pkg::*;
#(
  parameter int              NQ         = 8,
  parameter int              NW         = 16,
  parameter int              TW         = 32,
  parameter int              CW         = 8,
  parameter int              SW         = 16,
  parameter int              SDU_DEF    = 2048,
  parameter int              STEP_NS    = 8,
  parameter longint unsigned MIN_CYC_NS = 64'd1000000,
  parameter longint unsigned MAX_CYC_NS = 64'd4000000000,
  localparam int IW = $clog2(NW),
  localparam int LW = $clog2(NW + 1),
  localparam int QW = $clog2(NQ)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmd_valid_i,
  input  logic [1:0]       cmd_i,
  input  logic             sh_we_i,
  input  logic [IW-1:0]    sh_idx_i,
  input  logic [NQ-1:0]    sh_mask_i,
  input  logic [TW-1:0]    sh_end_i,
  input  logic [TW-1:0]    adm_cycle_i,
  input  logic [LW-1:0]    adm_len_i,
  input  logic [CW-1:0]    chg_count_i,
  input  logic             trig_i,
  input  logic             sdu_we_i,
  input  logic [QW-1:0]    sdu_q_i,
  input  logic [SW-1:0]    sdu_val_i,
  output logic [NQ-1:0]    gate_o,
  output logic             act_idx_o,
  output logic             change_o,
  output logic             pending_o,
  output logic             err_o,
  output logic [NQ*SW-1:0] max_sdu_o
);
  gs_cmd_e       cmd;
  logic          cmd_off, cmd_on, cmd_clr, cmd_bad;
  logic          en_q, pend_q, chg_q, err_q, act_q;
  logic [CW-1:0] rem_q;
  logic [NQ-1:0] act_mask;
  logic [TW-1:0] act_end, act_cyc;
  logic [LW-1:0] act_len;
  logic [IW-1:0] ptr;
  logic          act_empty, run, last, wrap, swap;
  logic          cyc_ok, len_ok, trig_ok;

  assign cmd     = gs_cmd_e'(cmd_i);
  assign cmd_off = cmd_valid_i && cmd == CMD_OFF;
  assign cmd_on  = cmd_valid_i && cmd == CMD_ON;
  assign cmd_clr = cmd_valid_i && cmd == CMD_CLR;
  assign cmd_bad = cmd_valid_i && cmd == CMD_BAD;

  assign act_empty = act_len == '0;
  assign run       = en_q && !act_empty;
  assign last      = (LW'(ptr) + LW'(1)) == act_len;

  assign cyc_ok  = adm_cycle_i >= TW'(MIN_CYC_NS) && adm_cycle_i <= TW'(MAX_CYC_NS);
  assign len_ok  = adm_len_i != '0 && adm_len_i <= LW'(NW);
  assign trig_ok = trig_i && !pend_q && cyc_ok && len_ok && !cmd_clr;
  assign swap    = pend_q && !cmd_clr && ((wrap && rem_q == CW'(1)) || act_empty);

  gs_gcl_store #(.NQ(NQ), .NW(NW), .TW(TW)) i_store (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (cmd_clr),
    .act_i    (act_q),
    .we_i     (sh_we_i),
    .widx_i   (sh_idx_i),
    .wmask_i  (sh_mask_i),
    .wend_i   (sh_end_i),
    .commit_i (trig_ok),
    .ccyc_i   (adm_cycle_i),
    .clen_i   (adm_len_i),
    .rptr_i   (ptr),
    .mask_o   (act_mask),
    .end_o    (act_end),
    .cyc_o    (act_cyc),
    .len_o    (act_len)
  );

  gs_cycle_timer #(.NW(NW), .TW(TW), .STEP_NS(STEP_NS)) i_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (run),
    .restart_i (cmd_on || cmd_clr),
    .cyc_i     (act_cyc),
    .end_i     (act_end),
    .last_i    (last),
    .ptr_o     (ptr),
    .wrap_o    (wrap)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      pend_q <= 1'b0;
      chg_q  <= 1'b0;
      err_q  <= 1'b0;
      act_q  <= 1'b0;
      rem_q  <= '0;
    end else if (cmd_clr) begin
      en_q   <= 1'b0;
      pend_q <= 1'b0;
      chg_q  <= 1'b0;
      err_q  <= trig_i;
      act_q  <= 1'b0;
      rem_q  <= '0;
    end else begin
      err_q <= cmd_bad || (trig_i && !trig_ok);
      chg_q <= trig_ok;
      if (cmd_off)     en_q <= 1'b0;
      else if (cmd_on) en_q <= 1'b1;
      if (trig_ok) begin
        pend_q <= 1'b1;
        rem_q  <= (chg_count_i == '0) ? CW'(1) : chg_count_i;
      end else if (swap) begin
        pend_q <= 1'b0;
        act_q  <= ~act_q;
      end else if (pend_q && wrap) begin
        rem_q <= rem_q - CW'(1);
      end
    end
  end

  for (genvar q = 0; q < NQ; q++) begin : g_sdu
    logic [SW-1:0] sdu_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                sdu_q <= SW'(SDU_DEF);
      else if (cmd_clr)                           sdu_q <= SW'(SDU_DEF);
      else if (sdu_we_i && sdu_q_i == QW'(q))     sdu_q <= sdu_val_i;
    end
    assign max_sdu_o[q*SW +: SW] = sdu_q;
  end

  assign gate_o    = run ? act_mask : '1;
  assign act_idx_o = act_q;
  assign change_o  = chg_q;
  assign pending_o = pend_q;
  assign err_o     = err_q;

  AST_ACK_NEXT_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    change_o |=> !change_o);  // R5
  AST_CHANGE_IMPLIES_PENDING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    change_o |-> pending_o);  // R5
  AST_INDEX_MOVES_ON_SWAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(act_idx_o) |-> ($fell(pending_o) || $past(cmd_clr)));  // R6
  AST_IDLE_GATES_OPEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_q |-> gate_o == '1);  // R8
  AST_BAD_CMD_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_bad |=> err_o);  // R8
  AST_CLEAR_RESTORES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_clr |=> (!act_idx_o && !pending_o && max_sdu_o[SW-1:0] == SW'(SDU_DEF)));  // R8
endmodule

// File: tb/test_gate_sched.sv
`timescale 1ns/1ps
module test_gate_sched;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 0;
  logic [1:0]  cmd = 0;
  logic        sh_we = 0;
  logic [3:0]  sh_idx = 0;
  logic [7:0]  sh_mask = 0;
  logic [31:0] sh_end = 0;
  logic [31:0] adm_cycle = 0;
  logic [4:0]  adm_len = 0;
  logic [7:0]  chg_count = 0;
  logic        trig = 0;
  logic        sdu_we = 0;
  logic [2:0]  sdu_q = 0;
  logic [15:0] sdu_val = 0;
  logic [7:0]  gate;
  logic        act_idx, change, pending, err;
  logic [127:0] max_sdu;

  always #4 clk = ~clk;

  gate_sched #(.STEP_NS(1), .MIN_CYC_NS(64'd12), .MAX_CYC_NS(64'd500)) i_gate_sched (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cmd_valid), .cmd_i(cmd),
    .sh_we_i(sh_we), .sh_idx_i(sh_idx), .sh_mask_i(sh_mask), .sh_end_i(sh_end),
    .adm_cycle_i(adm_cycle), .adm_len_i(adm_len), .chg_count_i(chg_count), .trig_i(trig),
    .sdu_we_i(sdu_we), .sdu_q_i(sdu_q), .sdu_val_i(sdu_val),
    .gate_o(gate), .act_idx_o(act_idx), .change_o(change), .pending_o(pending),
    .err_o(err), .max_sdu_o(max_sdu)
  );

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  string cur_req = "R2";

  // reference model
  logic [7:0] b_mask [2][16];
  int         b_end  [2][16];
  int         b_len  [2];
  int         b_cyc  [2];
  int  m_act = 0, m_rem = 0, m_t = 0;
  bit  m_pend = 0, m_chg = 0, m_run = 0, m_err = 0;

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h at %0t", req, got, exp, $time);
    end
  endtask

  function automatic logic [7:0] mask_at(int b, int t);
    for (int w = 0; w < b_len[b]; w++) begin
      int e = (w == b_len[b] - 1) ? b_cyc[b] : b_end[b][w];
      if (t < e) return b_mask[b][w];
    end
    return 8'h00;
  endfunction

  task automatic tick();
    bit empty, wrap, swap, tok;
    int oa;
    @(posedge clk);
    oa = m_act;
    m_err = 0;
    if (sh_we) begin
      b_mask[1-oa][sh_idx] = sh_mask;
      b_end[1-oa][sh_idx]  = sh_end;
    end
    if (cmd_valid && cmd == 2) begin
      m_run = 0; m_t = 0; m_act = 0; m_pend = 0; m_chg = 0; m_rem = 0;
      b_len[0] = 0; b_len[1] = 0;
    end else begin
      empty = (b_len[oa] == 0);
      wrap  = m_run && !empty && (m_t + 1 >= b_cyc[oa]);
      swap  = m_pend && ((wrap && m_rem == 1) || empty);
      tok   = trig && !m_pend && adm_cycle >= 12 && adm_cycle <= 500
              && adm_len != 0 && adm_len <= 16;
      if (cmd_valid && cmd == 1) m_t = 0;
      else if (wrap) m_t = 0;
      else if (m_run && !empty) m_t++;
      if (swap) begin m_act = 1 - oa; m_pend = 0; end
      else if (m_pend && wrap) m_rem--;
      m_chg = tok;
      if (tok) begin
        m_pend = 1;
        m_rem = (chg_count == 0) ? 1 : int'(chg_count);
        b_len[1-oa] = int'(adm_len);
        b_cyc[1-oa] = int'(adm_cycle);
      end
      if (cmd_valid && cmd == 0) m_run = 0;
      if (cmd_valid && cmd == 1) m_run = 1;
      if ((cmd_valid && cmd == 3) || (trig && !tok)) m_err = 1;
    end
    #1;
    check(cur_req, gate, (m_run && b_len[m_act] != 0) ? mask_at(m_act, m_t) : 8'hFF);
    check("R6 act_idx", act_idx, m_act);
    check("R6 pending", pending, m_pend);
    check("R5 change", change, m_chg);
    check("R4 err", err, m_err);
    cmd_valid = 0; sh_we = 0; trig = 0; sdu_we = 0;
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic wr(int idx, logic [7:0] m, int e);
    sh_we = 1; sh_idx = 4'(idx); sh_mask = m; sh_end = e;
    tick();
  endtask

  task automatic trigger(int cyc, int len, int cnt);
    trig = 1; adm_cycle = cyc; adm_len = 5'(len); chg_count = 8'(cnt);
    tick();
  endtask

  task automatic command(int c);
    cmd_valid = 1; cmd = 2'(c);
    tick();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 8);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    b_len[0] = 0; b_len[1] = 0; b_cyc[0] = 0; b_cyc[1] = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R1 reset state
    check("R1 gate", gate, 8'hFF);
    check("R1 act_idx", act_idx, 0);
    check("R1 flags", {change, pending, err}, 0);
    for (int q = 0; q < 8; q++) check("R1 max_sdu", max_sdu[q*16 +: 16], 2048);

    // R9 max frame size write
    sdu_we = 1; sdu_q = 3; sdu_val = 16'd1500;
    tick();
    for (int q = 0; q < 8; q++)
      check("R9 max_sdu", max_sdu[q*16 +: 16], (q == 3) ? 1500 : 2048);

    // list A: last raw end 14 must stretch to 20, entry 3 beyond length
    wr(0, 8'h01, 5);
    wr(1, 8'h06, 12);
    wr(2, 8'hF0, 14);
    wr(3, 8'hAA, 18);
    trigger(20, 3, 1);
    check("R5 change set", change, 1);
    tick();
    check("R7 empty swap", act_idx, 1);
    check("R7 pending clear", pending, 0);

    command(1);
    cur_req = "R3 stretch";
    run(45);

    // R4 rejected triggers keep schedule
    cur_req = "R4 schedule kept";
    trigger(10, 3, 1);
    check("R4 low cycle", err, 1);
    run(3);
    trigger(600, 3, 1);
    check("R4 high cycle", err, 1);
    trigger(20, 0, 1);
    check("R4 zero length", err, 1);
    trigger(20, 17, 1);
    check("R4 long list", err, 1);
    run(5);

    // list B into shadow, swap after 3 boundaries
    cur_req = "R2";
    wr(0, 8'h80, 3);
    wr(1, 8'h3C, 7);
    wr(2, 8'h00, 9);
    wr(3, 8'h41, 11);
    cur_req = "R6 boundary";
    trigger(16, 4, 3);
    trigger(16, 4, 3);
    check("R4 trigger while pending", err, 1);
    run(90);
    check("R6 swapped to B", act_idx, 0);

    // count 0 behaves as 1, back to list A
    trigger(20, 3, 0);
    run(40);
    check("R6 count zero", act_idx, 1);

    // R8 disable keeps config, enable restarts
    cur_req = "R8 disable";
    command(0);
    check("R8 gate open", gate, 8'hFF);
    run(7);
    check("R8 index kept", act_idx, 1);
    command(1);
    check("R8 restart window 0", gate, 8'h01);
    run(25);
    command(3);
    check("R8 bad command", err, 1);
    run(5);

    // R8 clear
    command(2);
    check("R8 clear index", act_idx, 0);
    check("R8 clear gate", gate, 8'hFF);
    for (int q = 0; q < 8; q++) check("R8 clear max_sdu", max_sdu[q*16 +: 16], 2048);
    command(1);
    run(5);
    check("R8 empty enabled gate", gate, 8'hFF);
    finish_run();
  end
endmodule